// File: doc/BRIEF.md
# Latched Fault Status Register Bank

This block gathers the fault states of six low-side driver channels into two readable status words. Each channel reports three kinds of fault: short to supply, short to ground and open load. Each of these 18 states sets a sticky bit in the bank. A sticky bit clears only when a serial transfer completes at a moment when its fault state is no longer present. The first status word also carries three flags. A logic-reset flag shows that the bank came out of reset. The undervoltage and overtemperature flags follow their detector levels directly.

A serial shifter outside this block pulses `xfer_start` when a frame begins and `xfer_done` when it ends. It shifts out the two words, which the block holds frozen from the start pulse through the done pulse. While no transfer is in progress, the words follow the internal state one cycle behind. The parameter `STRICT_ARM` selects how strictly a transfer must follow a cleared fault before that fault's bit is released.

Top module: `fault_status_bank`

## Requirements
- R1: A clock edge with `rst_n` low clears every fault bit and sets the logic-reset flag (word A bit 0). After that edge, word A shows the live undervoltage (bit 1) and overtemperature (bit 2) levels and word B reads zero.
- R2: Suppose a fault state is high at edge t and no transfer is open at edge t+1. Then its bit reads 1 after edge t+1.
- R3: A fault bit stays set after its state drops, and stays set across any number of idle cycles. When a transfer completes with the state low, the bit reads 0 one edge after the done edge.
- R4: A fault bit whose state is still high at the done edge stays set after the transfer.
- R5: The first completed transfer after reset clears the logic-reset flag. The flag stays clear until the next reset.
- R6: When no transfer is open, word A bits 1 and 2 show, after each edge, the undervoltage and overtemperature levels sampled at that edge.
- R7: Both words hold the value captured at the start edge until the edge after the done edge.
- R8: Fault state index 3*ch+k uses kind k, where 0 is short to supply, 1 is short to ground and 2 is open load. Channels 0 to 2 map to word A bit 3+3*ch+k. Channels 3 to 5 map to word B bit 3*(ch-3)+k.
- R9: With `STRICT_ARM`=1, a transfer clears a bit only if the bit's state was low at the start edge and at every edge through the done edge. A bit whose state was high at the start edge survives that transfer and clears on a later transfer that meets this condition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (already filtered) |
| fault_state | input | 18 | Live channel fault states, index 3*ch+kind |
| uv_level | input | 1 | Undervoltage detector level |
| ot_level | input | 1 | Overtemperature detector level |
| xfer_start | input | 1 | One-cycle pulse at serial frame start |
| xfer_done | input | 1 | One-cycle pulse at serial frame end |
| reg_a_q | output | 12 | Status word A: flags and channels 0 to 2 |
| reg_b_q | output | 12 | Status word B: channels 3 to 5 |

## Verification
The bench builds two copies of the block from the same stimulus. The first uses the default `STRICT_ARM`=0. The second uses `STRICT_ARM`=1. Comparing the two shows the case where a fault is present at the start of a frame and gone at its end: the default copy releases the bit, and the strict copy keeps it for one more frame. Both copies use the default six-channel, 12-bit layout, so every kind lands at a fixed bit position in each word that the bench can check.

// File: rtl/flt_pkg.sv
package flt_pkg;
   typedef enum logic [1:0] {
      FK_SHORT_SUPPLY = 2'd0,
      FK_SHORT_GROUND = 2'd1,
      FK_OPEN_LOAD    = 2'd2
   } fault_kind_e;

   localparam int FLAG_BITS = 3;
   localparam int LR_POS    = 0;
   localparam int UV_POS    = 1;
   localparam int OT_POS    = 2;
endpackage

// File: rtl/flt_latch_cell.sv
module flt_latch_cell #(
   parameter bit STRICT_ARM = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic state,
   input  logic start,
   input  logic done,
   output logic flag
);
   generate
      if (STRICT_ARM) begin : g_strict
         logic quiet;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               quiet <= 1'b0;
               flag  <= 1'b0;
            end else begin
               quiet <= start ? ~state : (quiet & ~state);
               if (done)
                  flag <= state | (flag & ~(quiet & ~state));
               else
                  flag <= flag | state;
            end
         end
      end else begin : g_loose
         always_ff @(posedge clk) begin
            if (!rst_n)
               flag <= 1'b0;
            else if (done)
               flag <= state;
            else
               flag <= flag | state;
         end
      end
   endgenerate
endmodule

// File: rtl/flt_flag_ctrl.sv
module flt_flag_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic done,
   output logic lr_q,
   output logic busy_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lr_q   <= 1'b1;
         busy_q <= 1'b0;
      end else begin
         if (done)
            lr_q <= 1'b0;
         if (start)
            busy_q <= 1'b1;
         else if (done)
            busy_q <= 1'b0;
      end
   end
endmodule

// File: rtl/flt_snapshot.sv
module flt_snapshot #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         busy,
   input  logic [W-1:0] image,
   input  logic [W-1:0] rst_image,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= rst_image;
      else if (!busy)
         q <= image;
   end
endmodule

// File: rtl/fault_status_bank.sv
module fault_status_bank #(
   parameter int NUM_CH     = 6,
   parameter int KINDS      = 3,
   parameter int REG_W      = 12,
   parameter bit STRICT_ARM = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_CH*KINDS-1:0]   fault_state,
   input  logic                      uv_level,
   input  logic                      ot_level,
   input  logic                      xfer_start,
   input  logic                      xfer_done,
   output logic [REG_W-1:0]          reg_a_q,
   output logic [REG_W-1:0]          reg_b_q
);
   import flt_pkg::*;

   localparam int TOTAL  = NUM_CH * KINDS;
   localparam int CH_LO  = NUM_CH / 2;
   localparam int BITS_A = FLAG_BITS + CH_LO * KINDS;
   localparam int BITS_B = (NUM_CH - CH_LO) * KINDS;
   localparam int B_BASE = CH_LO * KINDS;

   generate
      if (NUM_CH < 2) begin : g_bad_ch
         $error("fault_status_bank: NUM_CH must be at least 2");
      end
      if (KINDS < 1) begin : g_bad_kinds
         $error("fault_status_bank: KINDS must be at least 1");
      end
      if (REG_W < BITS_A) begin : g_bad_wa
         $error("fault_status_bank: REG_W too small for word A");
      end
      if (REG_W < BITS_B) begin : g_bad_wb
         $error("fault_status_bank: REG_W too small for word B");
      end
   endgenerate

   logic [TOTAL-1:0] flags;
   logic             lr_q;
   logic             busy_q;

   genvar gi;
   generate
      for (gi = 0; gi < TOTAL; gi++) begin : g_cell
         flt_latch_cell #(.STRICT_ARM(STRICT_ARM)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .state (fault_state[gi]),
            .start (xfer_start),
            .done  (xfer_done),
            .flag  (flags[gi])
         );
      end
   endgenerate

   flt_flag_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (xfer_start),
      .done   (xfer_done),
      .lr_q   (lr_q),
      .busy_q (busy_q)
   );

   logic [REG_W-1:0] img_a, img_b, rst_a, rst_b;

   always_comb begin
      img_a = '0;
      img_b = '0;
      img_a[LR_POS] = lr_q;
      img_a[UV_POS] = uv_level;
      img_a[OT_POS] = ot_level;
      for (int i = 0; i < B_BASE; i++)
         img_a[FLAG_BITS + i] = flags[i];
      for (int i = 0; i < BITS_B; i++)
         img_b[i] = flags[B_BASE + i];
      rst_a = '0;
      rst_b = '0;
      rst_a[LR_POS] = 1'b1;
      rst_a[UV_POS] = uv_level;
      rst_a[OT_POS] = ot_level;
   end

   flt_snapshot #(.W(REG_W)) u_snap_a (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy_q),
      .image     (img_a),
      .rst_image (rst_a),
      .q         (reg_a_q)
   );

   flt_snapshot #(.W(REG_W)) u_snap_b (
      .clk       (clk),
      .rst_n     (rst_n),
      .busy      (busy_q),
      .image     (img_b),
      .rst_image (rst_b),
      .q         (reg_b_q)
   );
endmodule

// File: rtl/fault_status_bank_chk.sv
module fault_status_bank_chk #(
   parameter int NUM_CH = 6,
   parameter int KINDS  = 3,
   parameter int REG_W  = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [NUM_CH*KINDS-1:0] fault_state,
   input logic                    uv_level,
   input logic                    ot_level,
   input logic                    xfer_start,
   input logic                    xfer_done,
   input logic [REG_W-1:0]        reg_a_q,
   input logic [REG_W-1:0]        reg_b_q
);
   localparam int B_BASE = (NUM_CH / 2) * KINDS;

   logic in_x;
   always_ff @(posedge clk) begin
      if (!rst_n)
         in_x <= 1'b0;
      else if (xfer_start)
         in_x <= 1'b1;
      else if (xfer_done)
         in_x <= 1'b0;
   end

   // R1: reset sets logic-reset flag and empties word B
   assert_reset_image_R1: assert property (@(posedge clk)
      !rst_n |=> (reg_a_q[0] && reg_b_q == '0));

   // R2: a fault state shows up when no transfer holds the words
   assert_fault_sets_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fault_state[0] ##1 !in_x |=> reg_a_q[3]);

   assert_fault_sets_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fault_state[B_BASE] ##1 !in_x |=> reg_b_q[0]);

   // R5: completed transfer clears the logic-reset flag
   assert_lr_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done ##1 rst_n |=> !reg_a_q[0]);

   // R6: detector flags track their levels while idle
   assert_live_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_x |=> (reg_a_q[1] == $past(uv_level) && reg_a_q[2] == $past(ot_level)));

   // R7: words frozen while a transfer is open
   assert_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_x |=> ($stable(reg_a_q) && $stable(reg_b_q)));
endmodule

bind fault_status_bank fault_status_bank_chk #(
   .NUM_CH (NUM_CH),
   .KINDS  (KINDS),
   .REG_W  (REG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fault_state (fault_state),
   .uv_level    (uv_level),
   .ot_level    (ot_level),
   .xfer_start  (xfer_start),
   .xfer_done   (xfer_done),
   .reg_a_q     (reg_a_q),
   .reg_b_q     (reg_b_q)
);

// File: tb/sim_fault_status_bank.sv
`timescale 1ns/1ps
module sim_fault_status_bank;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [17:0] fs;
   logic        uv, ot, start, done;
   logic [11:0] a0, b0, a1, b1;

   always #5 clk = ~clk;

   fault_status_bank u0 (
      .clk(clk), .rst_n(rst_n), .fault_state(fs), .uv_level(uv), .ot_level(ot),
      .xfer_start(start), .xfer_done(done), .reg_a_q(a0), .reg_b_q(b0));

   fault_status_bank #(.STRICT_ARM(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .fault_state(fs), .uv_level(uv), .ot_level(ot),
      .xfer_start(start), .xfer_done(done), .reg_a_q(a1), .reg_b_q(b1));

   typedef struct {
      int          inst;
      logic [11:0] a;
      logic [11:0] b;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   vectors = 0;
   int   miscompares = 0;
   bit   finished = 0;

   // monitor: compares queued expectations between edges
   always @(negedge clk) begin
      while (q.size() > 0) begin
         exp_t e;
         logic [11:0] ga, gb;
         e = q.pop_front();
         ga = (e.inst == 0) ? a0 : a1;
         gb = (e.inst == 0) ? b0 : b1;
         vectors++;
         if (ga !== e.a || gb !== e.b) begin
            miscompares++;
            $display("FAIL %s u%0d: actual A=%0d B=%0d expected A=%0d B=%0d",
                     e.tag, e.inst, ga, gb, e.a, e.b);
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic expect2(input logic [11:0] ea0, input logic [11:0] eb0,
                          input logic [11:0] ea1, input logic [11:0] eb1,
                          input string tag);
      exp_t e;
      e.inst = 0; e.a = ea0; e.b = eb0; e.tag = tag; q.push_back(e);
      e.inst = 1; e.a = ea1; e.b = eb1; e.tag = tag; q.push_back(e);
   endtask

   task automatic transfer();
      start = 1'b1; step(); start = 1'b0;
      done = 1'b1;  step(); done = 1'b0;
      step();
   endtask

   initial begin
      rst_n = 1'b0; fs = '0; uv = 1'b1; ot = 1'b0; start = 1'b0; done = 1'b0;
      step();
      expect2(12'd3, 12'd0, 12'd3, 12'd0, "R1 reset image");
      rst_n = 1'b1;
      step();
      expect2(12'd3, 12'd0, 12'd3, 12'd0, "R1 flag kept after release");
      uv = 1'b0; ot = 1'b1;
      step();
      expect2(12'd5, 12'd0, 12'd5, 12'd0, "R6 live detector flags");
      fs[0] = 1'b1; fs[13] = 1'b1;          // ch0 supply short, ch4 ground short
      step(); step();
      expect2(12'd13, 12'd16, 12'd13, 12'd16, "R2 R8 fault bits set");
      fs = '0;
      step(); step(); step();
      expect2(12'd13, 12'd16, 12'd13, 12'd16, "R3 bits held after state drops");
      start = 1'b1; step(); start = 1'b0;
      uv = 1'b1;
      step();
      expect2(12'd13, 12'd16, 12'd13, 12'd16, "R7 frozen during transfer");
      done = 1'b1; step(); done = 1'b0;
      expect2(12'd13, 12'd16, 12'd13, 12'd16, "R7 frozen through done edge");
      step();
      expect2(12'd6, 12'd0, 12'd6, 12'd0, "R3 R5 cleared after transfer");
      fs[5] = 1'b1;                          // ch1 open load
      step(); step();
      expect2(12'd262, 12'd0, 12'd262, 12'd0, "R8 ch1 open load position");
      transfer();
      expect2(12'd262, 12'd0, 12'd262, 12'd0, "R4 R5 active fault survives transfer");
      fs[5] = 1'b0; fs[17] = 1'b1;           // ch5 open load
      step(); step();
      expect2(12'd262, 12'd256, 12'd262, 12'd256, "R8 ch5 open load position");
      start = 1'b1; step(); start = 1'b0;
      fs[17] = 1'b0;
      step();
      done = 1'b1; step(); done = 1'b0;
      step();
      expect2(12'd6, 12'd0, 12'd6, 12'd256, "R9 strict keeps bit active at start");
      transfer();
      expect2(12'd6, 12'd0, 12'd6, 12'd0, "R9 strict clears on later transfer");
      fs[2] = 1'b1; fs[9] = 1'b1; rst_n = 1'b0;
      step();
      expect2(12'd7, 12'd0, 12'd7, 12'd0, "R1 reset clears bits with fault active");
      fs = '0; rst_n = 1'b1;
      step(); step();
      expect2(12'd7, 12'd0, 12'd7, 12'd0, "R5 flag set again after reset");
      step(); step();
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         miscompares++;
         $display("FAIL R7 watchdog: actual=running expected=finished");
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule